// File: doc/BRIEF.md
# I2C Slave Automatic Clock-Stretch Controller

This block decides when an I2C slave must pull SCL low because its two-byte transmit or receive FIFO cannot keep pace with the bus. The slave protocol engine tells it when an SCL falling edge arrives and what the bus is about to do at that edge: the acknowledge slot of an address byte, the first bit of a data byte, or the acknowledge slot of a received byte. It also supplies the transfer direction and both FIFO occupancy counts. From these the block raises an active-high, registered SCL pull-low request.

A 4-bit mode input selects between no automatic stretching, stretching capped by a timeout, and stretching with no cap. The timeout runs on a prescaled system clock, so it does not depend on the bus bit rate. A stretch that ends because the cap was reached sets a sticky flag, which a status read clears. A write-one soft-reset strobe produces a one-cycle pulse that clears line-busy status and restarts the start/stop detectors.

Top module: `i2c_stretch_ctrl`

## Requirements
- R1: After reset, `scl_hold`, `tmo_sticky` and `det_reset` are all 0.
- R2: With stretching enabled (`slv_en`=1, mode not 0000) and `dir_tx`=1, a cycle with `scl_fall`=1 and either `at_addr_ack` or `at_data_start` set, while `tx_level`=00 (empty), makes `scl_hold` 1 from the next cycle.
- R3: A transmit-side hold ends (`scl_hold` 0 in the next cycle, flag untouched) in the first cycle in which `tx_level` is not 00.
- R4: With stretching enabled and `dir_tx`=0, a cycle with `scl_fall`=1 and `at_rx_ack`=1, while `rx_level`=10 (two bytes, full), makes `scl_hold` 1 from the next cycle.
- R5: A receive-side hold ends (`scl_hold` 0 in the next cycle, flag untouched) in the first cycle in which `rx_level` is not 10.
- R6: No hold starts without `scl_fall`, without the matching phase input, with mode 0000, with `slv_en`=0, or when the FIFO is not empty (transmit) or not full (receive).
- R7: For mode m from 0001 to 1110, a hold whose FIFO condition persists lasts exactly PRESC_DIV×2^m clock cycles. It is then released, and `tmo_sticky` becomes 1 in the same cycle.
- R8: Mode 1111 never times out. The hold lasts until the FIFO condition clears.
- R9: `tmo_sticky` stays 1 until a cycle with `stat_rd`=1 and is 0 from the next cycle. A timeout in the same cycle as a read leaves the flag at 1.
- R10: While holding, `slv_en`=0 or mode 0000 releases `scl_hold` in the next cycle without touching the flag.
- R11: `rst_wr`=1 with `rst_wdata`=1 gives `det_reset`=1 for exactly the next cycle. `rst_wr`=1 with `rst_wdata`=0 leaves `det_reset` at 0.
- R12: After a timeout, no new hold begins until another qualifying SCL falling edge, even if the FIFO is still empty or full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slv_en | input | 1 | Slave mode active |
| scl_fall | input | 1 | One-cycle strobe marking an SCL falling edge |
| at_addr_ack | input | 1 | Edge precedes the acknowledge of an address byte |
| at_data_start | input | 1 | Edge precedes the first bit of a transmitted data byte |
| at_rx_ack | input | 1 | Edge precedes the acknowledge of a received byte |
| dir_tx | input | 1 | 1 = slave transmits, 0 = slave receives |
| tx_level | input | 2 | Transmit FIFO occupancy (00 empty, 01, 10) |
| rx_level | input | 2 | Receive FIFO occupancy (00 empty, 01, 10 full) |
| stretch_mode | input | 4 | 0000 off, 0001..1110 timed, 1111 no timeout |
| stat_rd | input | 1 | Status read strobe; clears the timeout flag |
| rst_wr | input | 1 | Soft-reset control write strobe |
| rst_wdata | input | 1 | Data bit written with `rst_wr` |
| scl_hold | output | 1 | Request to hold SCL low (registered) |
| tmo_sticky | output | 1 | Sticky stretch-timeout flag |
| det_reset | output | 1 | One-cycle pulse resetting line-busy status and start/stop detection |

## Verification
Every result of this block is due one clock edge after the inputs that cause it. This covers the start of a hold, its release when the FIFO level changes or the slave is disabled, the flag clearing, and the soft-reset pulse. A timeout release and the flag rising land together, exactly PRESC_DIV×2^m edges after the edge that raised the hold. The bench drives inputs on falling clock edges and updates a behavioural model on rising edges from those same inputs. It then compares all three outputs against the model on every following falling edge, so each output is checked in the cycle it is due and in every cycle around it.

// File: rtl/i2c_stretch_pkg.sv
package i2c_stretch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_HOLD_TX = 2'd1,
    ST_HOLD_RX = 2'd2
  } stretch_st_e;
endpackage

// File: rtl/i2c_stretch_rst_sync.sv
module i2c_stretch_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/i2c_stretch_timer.sv
module i2c_stretch_timer #(
  parameter int PRESC_DIV = 4,
  parameter int MODE_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic [MODE_W-1:0] mode,
  output logic              expire
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam int TW = (1 << MODE_W) - 1;
  localparam logic [MODE_W-1:0] MODE_INF = '1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESC_DIV - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [TW-1:0] limit;
  logic          tick;
  logic          cnt_en;

  assign tick   = run && (pre_q == PRE_LAST);
  assign limit  = (TW'(1) << mode) - TW'(1);
  assign expire = tick && (mode != MODE_INF) && (tcnt_q >= limit);
  assign cnt_en = clear || run;

  always_comb begin
    pre_d  = pre_q;
    tcnt_d = tcnt_q;
    if (clear) begin
      pre_d  = '0;
      tcnt_d = '0;
    end else if (run) begin
      if (tick) begin
        pre_d = '0;
        if (tcnt_q != '1) tcnt_d = tcnt_q + TW'(1);
      end else begin
        pre_d = pre_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tcnt_q <= '0;
    end else if (cnt_en) begin
      pre_q  <= pre_d;
      tcnt_q <= tcnt_d;
    end
  end

  // R8: the uncapped mode never reports expiry
  p_inf_no_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_INF) |-> !expire);
endmodule

// File: rtl/i2c_stretch_fsm.sv
module i2c_stretch_fsm
  import i2c_stretch_pkg::*;
#(
  parameter int MODE_W     = 4,
  parameter int LVL_W      = 2,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slv_en,
  input  logic              scl_fall,
  input  logic              at_addr_ack,
  input  logic              at_data_start,
  input  logic              at_rx_ack,
  input  logic              dir_tx,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [MODE_W-1:0] mode,
  input  logic              expire,
  output logic              hold,
  output logic              tmr_clear,
  output logic              tmr_run,
  output logic              tmo_evt
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  stretch_st_e st_q, st_d;
  logic        hold_q;
  logic        enabled, tx_empty, rx_full, go_tx, go_rx;

  assign enabled  = slv_en && (mode != '0);
  assign tx_empty = (tx_level == '0);
  assign rx_full  = (rx_level == FULL_LVL);
  assign go_tx    = enabled && scl_fall && dir_tx && (at_addr_ack || at_data_start) && tx_empty;
  assign go_rx    = enabled && scl_fall && !dir_tx && at_rx_ack && rx_full;

  always_comb begin
    st_d      = st_q;
    tmr_clear = 1'b0;
    tmo_evt   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go_tx) begin
          st_d      = ST_HOLD_TX;
          tmr_clear = 1'b1;
        end else if (go_rx) begin
          st_d      = ST_HOLD_RX;
          tmr_clear = 1'b1;
        end
      end
      ST_HOLD_TX: begin
        if (!enabled || !tx_empty) begin
          st_d = ST_IDLE;
        end else if (expire) begin
          st_d    = ST_IDLE;
          tmo_evt = 1'b1;
        end
      end
      ST_HOLD_RX: begin
        if (!enabled || !rx_full) begin
          st_d = ST_IDLE;
        end else if (expire) begin
          st_d    = ST_IDLE;
          tmo_evt = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hold_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hold_q <= (st_d != ST_IDLE);
    end
  end

  assign hold    = hold_q;
  assign tmr_run = (st_q != ST_IDLE);

  // R6: a hold only ever begins right after an SCL falling edge
  p_rise_after_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> $past(scl_fall));
  // R3: transmit FIFO refilled while holding -> released next cycle
  p_tx_refill_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD_TX && tx_level != '0) |=> !hold_q);
  // R5: receive FIFO drained while holding -> released next cycle
  p_rx_drain_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD_RX && rx_level != FULL_LVL) |=> !hold_q);
endmodule

// File: rtl/i2c_stretch_status.sv
module i2c_stretch_status (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo_evt,
  input  logic stat_rd,
  input  logic rst_wr,
  input  logic rst_wdata,
  output logic tmo_sticky,
  output logic det_reset
);
  logic flag_q, flag_d;
  logic det_q, det_d;

  always_comb begin
    flag_d = flag_q;
    if (tmo_evt)      flag_d = 1'b1;
    else if (stat_rd) flag_d = 1'b0;
    det_d = rst_wr && rst_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      det_q  <= det_d;
    end
  end

  assign tmo_sticky = flag_q;
  assign det_reset  = det_q;

  // R7: a timeout event is always recorded
  p_flag_on_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> tmo_sticky);
  // R9: a read without a concurrent timeout clears the flag
  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tmo_evt) |=> !tmo_sticky);
  // R11: writing zero never pulses the detector reset
  p_zero_write_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_wr && rst_wdata) |=> !det_reset);
endmodule

// File: rtl/i2c_stretch_ctrl.sv
module i2c_stretch_ctrl #(
  parameter int PRESC_DIV  = 4,
  parameter int MODE_W     = 4,
  parameter int LVL_W      = 2,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slv_en,
  input  logic              scl_fall,
  input  logic              at_addr_ack,
  input  logic              at_data_start,
  input  logic              at_rx_ack,
  input  logic              dir_tx,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [MODE_W-1:0] stretch_mode,
  input  logic              stat_rd,
  input  logic              rst_wr,
  input  logic              rst_wdata,
  output logic              scl_hold,
  output logic              tmo_sticky,
  output logic              det_reset
);
  logic rst_n_int;
  logic tmr_clear, tmr_run, expire, tmo_evt;

  i2c_stretch_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  i2c_stretch_fsm #(
    .MODE_W     (MODE_W),
    .LVL_W      (LVL_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .slv_en        (slv_en),
    .scl_fall      (scl_fall),
    .at_addr_ack   (at_addr_ack),
    .at_data_start (at_data_start),
    .at_rx_ack     (at_rx_ack),
    .dir_tx        (dir_tx),
    .tx_level      (tx_level),
    .rx_level      (rx_level),
    .mode          (stretch_mode),
    .expire        (expire),
    .hold          (scl_hold),
    .tmr_clear     (tmr_clear),
    .tmr_run       (tmr_run),
    .tmo_evt       (tmo_evt)
  );

  i2c_stretch_timer #(
    .PRESC_DIV (PRESC_DIV),
    .MODE_W    (MODE_W)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clear  (tmr_clear),
    .run    (tmr_run),
    .mode   (stretch_mode),
    .expire (expire)
  );

  i2c_stretch_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .tmo_evt    (tmo_evt),
    .stat_rd    (stat_rd),
    .rst_wr     (rst_wr),
    .rst_wdata  (rst_wdata),
    .tmo_sticky (tmo_sticky),
    .det_reset  (det_reset)
  );

  // R10: disabled slave or mode off -> no hold in the following cycle
  p_off_when_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!slv_en || stretch_mode == '0) |=> !scl_hold);
endmodule

// File: tb/i2c_stretch_ctrl_tb.sv
module i2c_stretch_ctrl_tb;
  localparam int PRESC = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic slv_en, scl_fall, at_addr_ack, at_data_start, at_rx_ack, dir_tx;
  logic [1:0] tx_level, rx_level;
  logic [3:0] mode;
  logic stat_rd, rst_wr, rst_wdata;
  logic scl_hold, tmo_sticky, det_reset;

  always #5 clk = ~clk;

  i2c_stretch_ctrl #(.PRESC_DIV(PRESC)) u_dut (
    .clk(clk), .rst_n(rst_n), .slv_en(slv_en), .scl_fall(scl_fall),
    .at_addr_ack(at_addr_ack), .at_data_start(at_data_start), .at_rx_ack(at_rx_ack),
    .dir_tx(dir_tx), .tx_level(tx_level), .rx_level(rx_level), .stretch_mode(mode),
    .stat_rd(stat_rd), .rst_wr(rst_wr), .rst_wdata(rst_wdata),
    .scl_hold(scl_hold), .tmo_sticky(tmo_sticky), .det_reset(det_reset));

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string req   = "R1";

  // behavioural reference
  bit m_hold, m_flag, m_det, m_tx;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = 0; m_flag = 0; m_det = 0; m_tx = 0; m_cnt = 0;
    end else begin
      bit en, evt;
      en  = slv_en && (mode != 0);
      evt = 0;
      m_det = rst_wr && rst_wdata;
      if (!m_hold) begin
        if (en && scl_fall && dir_tx && (at_addr_ack || at_data_start) && tx_level == 0) begin
          m_hold = 1; m_tx = 1; m_cnt = 0;
        end else if (en && scl_fall && !dir_tx && at_rx_ack && rx_level == 2) begin
          m_hold = 1; m_tx = 0; m_cnt = 0;
        end
      end else begin
        m_cnt++;
        if (!en) m_hold = 0;
        else if (m_tx ? (tx_level != 0) : (rx_level != 2)) m_hold = 0;
        else if (mode != 15 && m_cnt >= (PRESC << mode)) begin
          m_hold = 0; evt = 1;
        end
      end
      if (evt) m_flag = 1;
      else if (stat_rd) m_flag = 0;
    end
  end

  task automatic cmp(input string what, input logic act, input bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("scl_hold", scl_hold, m_hold);
      cmp("tmo_sticky", tmo_sticky, m_flag);
      cmp("det_reset", det_reset, m_det);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle SCL falling edge with chosen phase strobes
  task automatic edge_at(input bit a, input bit d, input bit r);
    scl_fall = 1; at_addr_ack = a; at_data_start = d; at_rx_ack = r;
    cyc(1);
    scl_fall = 0; at_addr_ack = 0; at_data_start = 0; at_rx_ack = 0;
  endtask

  task automatic rd_status();
    stat_rd = 1; cyc(1); stat_rd = 0;
  endtask

  initial begin
    rst_n = 0; slv_en = 0; scl_fall = 0; at_addr_ack = 0; at_data_start = 0;
    at_rx_ack = 0; dir_tx = 1; tx_level = 0; rx_level = 0; mode = 0;
    stat_rd = 0; rst_wr = 0; rst_wdata = 0;
    cyc(4);
    rst_n = 1;
    req = "R1"; cyc(6);

    req = "R2"; slv_en = 1; mode = 4'd3; dir_tx = 1; tx_level = 0;
    edge_at(1, 0, 0); cyc(3);
    req = "R3"; tx_level = 1; cyc(4);
    req = "R2"; tx_level = 0; edge_at(0, 1, 0); cyc(2);
    req = "R3"; tx_level = 2; cyc(4);

    req = "R6"; tx_level = 1; edge_at(1, 0, 0); cyc(3);
    tx_level = 0; edge_at(0, 0, 0); cyc(3);
    at_data_start = 1; cyc(2); at_data_start = 0; cyc(2);
    edge_at(0, 0, 1); cyc(3);
    mode = 0; edge_at(1, 0, 0); cyc(3);
    mode = 4'd3; slv_en = 0; edge_at(0, 1, 0); cyc(3);
    slv_en = 1; dir_tx = 0; rx_level = 1; edge_at(0, 0, 1); cyc(3);
    rx_level = 2; edge_at(1, 1, 0); cyc(3);

    req = "R4"; rx_level = 2; edge_at(0, 0, 1); cyc(3);
    req = "R5"; rx_level = 1; cyc(4);
    req = "R4"; rx_level = 2; edge_at(0, 0, 1); cyc(2);
    req = "R5"; rx_level = 0; cyc(4);

    req = "R7"; dir_tx = 1; tx_level = 0; mode = 4'd1;
    edge_at(1, 0, 0); cyc(14);
    req = "R12"; cyc(10);
    req = "R9"; rd_status(); cyc(3);
    req = "R7"; mode = 4'd5; dir_tx = 0; rx_level = 2;
    edge_at(0, 0, 1); cyc(140);
    req = "R12"; cyc(8);
    req = "R9"; rd_status(); cyc(2);
    // timeout and read in the same cycle: flag must stay set
    dir_tx = 1; tx_level = 0; mode = 4'd1;
    edge_at(0, 1, 0); cyc(7);
    stat_rd = 1; cyc(1); stat_rd = 0; cyc(4);
    rd_status(); cyc(3);

    req = "R8"; mode = 4'd15; edge_at(1, 0, 0); cyc(300);
    tx_level = 1; cyc(4);

    req = "R10"; tx_level = 0; mode = 4'd4; edge_at(1, 0, 0); cyc(5);
    slv_en = 0; cyc(4); slv_en = 1; cyc(3);
    edge_at(0, 1, 0); cyc(5);
    mode = 0; cyc(4); mode = 4'd4; cyc(3);
    tx_level = 1; cyc(2);

    req = "R11"; rst_wr = 1; rst_wdata = 1; cyc(1); rst_wr = 0; rst_wdata = 0; cyc(3);
    rst_wr = 1; rst_wdata = 0; cyc(1); rst_wr = 0; cyc(3);
    rst_wdata = 1; cyc(2); rst_wdata = 0; cyc(2);

    finish_run();
  end
endmodule